// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block is the queueing stage between software and the bit engine of an I2C master. Software pushes 11-bit command words through a small register port into a transmit queue. Each word either carries a byte to send or asks for one byte to be read. Two extra bits ask for a repeated start before the byte and a stop after it. The bit engine takes words from the head of the queue over a valid/ready handshake. It returns each received byte as a single-cycle valid pulse, and software pops received bytes by reading the command register.

Both queues report their fill levels. Two level conditions come from software-set watermarks: a transmit-low condition that asks for more commands, and a receive-high condition that asks for bytes to be drained. Three sticky error flags record a write into a full transmit queue, a read from an empty receive queue, and a byte that arrives while the receive queue is full. An abort pulse from the bit engine empties both queues at once.

Back-pressure rules: `cmd_valid` stays high while the transmit queue holds a word. A word leaves on a cycle where `cmd_valid` and `cmd_ready` are both high, and until then it stays at `cmd_data` unchanged. The receive input has no ready signal, because the engine cannot stall the bus. A byte that finds the queue full is dropped and flagged.

Top module: `i2cm_queue_top`

## Requirements
- R1: Command words leave at `cmd_data` in the order they were written, and received bytes are returned in arrival order by reads of register 0 (byte in bits 7:0). A word offered with `cmd_ready` low stays unchanged at `cmd_data` with `cmd_valid` held high.
- R2: A command word with bit 8 set is a read request. The queue stores it with bits 7:0 forced to zero. With bit 8 clear, bits 7:0 are the byte to send. Bit 9 (stop after the byte) and bit 10 (repeated start before the byte) pass through unchanged.
- R3: Register 1 returns the transmit fill level and register 2 returns the receive fill level. Each level is zero-extended.
- R4: Register 3 holds the transmit watermark, reset value DEPTH/2. `tx_empty_lvl` is high exactly when the transmit level is at or below it.
- R5: Register 4 holds the receive watermark, reset value 0. `rx_full_lvl` is high exactly when the receive level is above it.
- R6: A write to register 0 while the transmit queue holds DEPTH words is dropped and sets `tx_over` (flag bit 0). This holds even if a word leaves in the same cycle.
- R7: A read of register 0 with the receive queue empty returns 0, leaves the queue unchanged and sets `rx_under` (flag bit 1).
- R8: A byte that arrives while the receive queue holds DEPTH bytes is dropped and sets `rx_over` (flag bit 2). This holds even if software pops in the same cycle.
- R9: In a cycle where `xfer_abort` is high, both queues become empty and that cycle's pushes and pops are discarded without setting any flag. Watermark and flag-clear writes still take effect.
- R10: A push and a pop of the same queue in one cycle leave that queue's level unchanged.
- R11: Register 5 reads the three flags. Writing a 1 to a flag bit clears that flag, and an event that sets the flag in the same cycle wins over the clear.
- R12: After reset both queues are empty, all flags are clear, and the watermarks hold DEPTH/2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data, valid in the strobe cycle |
| cmd_valid | output | 1 | Transmit queue head is valid |
| cmd_ready | input | 1 | Bit engine accepts the head word |
| cmd_data | output | 11 | Head command word |
| rxb_valid | input | 1 | Received byte pulse |
| rxb_data | input | 8 | Received byte |
| xfer_abort | input | 1 | Transfer abort, empties both queues |
| tx_empty_lvl | output | 1 | Transmit level at or below watermark |
| rx_full_lvl | output | 1 | Receive level above watermark |
| tx_over | output | 1 | Sticky transmit overflow flag |
| rx_under | output | 1 | Sticky receive underflow flag |
| rx_over | output | 1 | Sticky receive overflow flag |

## Verification
The bench targets the edges of the queues. It writes into a full transmit queue while a word drains, delivers a byte into a full receive queue while software pops, and pushes and pops one queue in the same cycle. A design that tested fullness after the pop would accept the extra word or byte and leave the flag clear. A design that mishandled the combined push and pop would drift its level by one. The bench also sweeps the watermarks through their boundary values, which exposes an off-by-one compare as a wrong level condition. It fires aborts with traffic in flight, and a design that let a same-cycle push survive, or raised a flag during the abort, shows up in the levels read afterwards.

// File: rtl/i2cm_queue_pkg.sv
package i2cm_queue_pkg;
  localparam int CMD_W     = 11;
  localparam int BYTE_W    = 8;
  localparam int BIT_READ  = 8;
  localparam int BIT_STOP  = 9;
  localparam int BIT_RSTRT = 10;

  localparam logic [2:0] RA_CMD   = 3'd0;
  localparam logic [2:0] RA_TXLVL = 3'd1;
  localparam logic [2:0] RA_RXLVL = 3'd2;
  localparam logic [2:0] RA_TXTHR = 3'd3;
  localparam logic [2:0] RA_RXTHR = 3'd4;
  localparam logic [2:0] RA_FLAGS = 3'd5;

  typedef struct packed {
    logic rx_over;
    logic rx_under;
    logic tx_over;
  } err_flags_t;
endpackage

// File: rtl/i2cm_queue_fifo.sv
module i2cm_queue_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)) else $error("level above depth"); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)) else $error("flush left entries"); // R9
  AST_PUSHPOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty && !flush) |=> $stable(level))
    else $error("push+pop moved level"); // R10
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush) |=> (level <= LW'(DEPTH))) else $error("grew past full"); // R6
endmodule

// File: rtl/i2cm_queue_regs.sv
module i2cm_queue_regs
  import i2cm_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [LW-1:0]     thr_wdata,
  input  logic [2:0]        clr_bits,
  input  err_flags_t        set_ev,
  input  logic [LW-1:0]     tx_level,
  input  logic [LW-1:0]     rx_level,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_empty,
  output logic [CMD_W-1:0]  rdata,
  output logic [LW-1:0]     tx_thr,
  output logic [LW-1:0]     rx_thr,
  output err_flags_t        flags
);
  logic [2:0] clr;

  assign clr = (wr && addr == RA_FLAGS) ? clr_bits : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= LW'(DEPTH / 2);
      rx_thr <= '0;
      flags  <= '0;
    end else begin
      if (wr && addr == RA_TXTHR) tx_thr <= thr_wdata;
      if (wr && addr == RA_RXTHR) rx_thr <= thr_wdata;
      flags <= (flags & ~clr) | set_ev;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CMD:   rdata = rx_empty ? '0 : CMD_W'(rx_byte);
      RA_TXLVL: rdata = CMD_W'(tx_level);
      RA_RXLVL: rdata = CMD_W'(rx_level);
      RA_TXTHR: rdata = CMD_W'(tx_thr);
      RA_RXTHR: rdata = CMD_W'(rx_thr);
      RA_FLAGS: rdata = CMD_W'(flags);
      default:  rdata = '0;
    endcase
  end

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_FLAGS && clr_bits[0] && !set_ev.tx_over) |=> !flags.tx_over)
    else $error("flag clear ignored"); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev.rx_over |=> flags.rx_over) else $error("set lost"); // R11
endmodule

// File: rtl/i2cm_queue_top.sv
module i2cm_queue_top
  import i2cm_queue_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [10:0] reg_wdata,
  output logic [10:0] reg_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [10:0] cmd_data,
  input  logic        rxb_valid,
  input  logic [7:0]  rxb_data,
  input  logic        xfer_abort,
  output logic        tx_empty_lvl,
  output logic        rx_full_lvl,
  output logic        tx_over,
  output logic        rx_under,
  output logic        rx_over
);
  localparam int LW = $clog2(DEPTH + 1);

  logic              cmd_wr, rx_pop, tx_pop;
  logic [CMD_W-1:0]  canon;
  logic [LW-1:0]     tx_level, rx_level, tx_thr, rx_thr;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_byte;
  err_flags_t        set_ev, flags;

  assign cmd_wr = reg_wr && (reg_addr == RA_CMD);
  assign rx_pop = reg_rd && (reg_addr == RA_CMD);
  assign canon  = reg_wdata[BIT_READ]
                ? {reg_wdata[BIT_RSTRT:BIT_READ], {BYTE_W{1'b0}}}
                : reg_wdata;

  assign cmd_valid = !tx_empty;
  assign tx_pop    = cmd_valid && cmd_ready;

  i2cm_queue_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(xfer_abort),
    .push(cmd_wr), .din(canon), .pop(tx_pop), .dout(cmd_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  i2cm_queue_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(xfer_abort),
    .push(rxb_valid), .din(rxb_data), .pop(rx_pop), .dout(rx_byte),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign set_ev.tx_over  = cmd_wr && tx_full && !xfer_abort;
  assign set_ev.rx_under = rx_pop && rx_empty && !xfer_abort;
  assign set_ev.rx_over  = rxb_valid && rx_full && !xfer_abort;

  i2cm_queue_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .thr_wdata(reg_wdata[LW-1:0]), .clr_bits(reg_wdata[2:0]),
    .set_ev(set_ev), .tx_level(tx_level), .rx_level(rx_level),
    .rx_byte(rx_byte), .rx_empty(rx_empty), .rdata(reg_rdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .flags(flags)
  );

  assign tx_empty_lvl = (tx_level <= tx_thr);
  assign rx_full_lvl  = (rx_level > rx_thr);
  assign tx_over      = flags.tx_over;
  assign rx_under     = flags.rx_under;
  assign rx_over      = flags.rx_over;

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !xfer_abort) |=> (cmd_valid && $stable(cmd_data)))
    else $error("head changed while stalled"); // R1
  AST_READ_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data[BIT_READ]) |-> (cmd_data[7:0] == 8'h00))
    else $error("read word kept byte"); // R2
  AST_TXOVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && tx_full && !xfer_abort) |=> tx_over) else $error("tx_over missed"); // R6
  AST_RXUNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty && !xfer_abort) |=> rx_under) else $error("rx_under missed"); // R7
  AST_RXOVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rxb_valid && rx_full && !xfer_abort) |=> rx_over) else $error("rx_over missed"); // R8
endmodule

// File: tb/sim_i2cm_queue_top.sv
module sim_i2cm_queue_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, cmd_ready = 0, rxb_valid = 0, xfer_abort = 0;
  logic [2:0] reg_addr = '0;
  logic [10:0] reg_wdata = '0;
  logic [7:0] rxb_data = '0;
  logic [10:0] reg_rdata, cmd_data;
  logic cmd_valid, tx_empty_lvl, rx_full_lvl, tx_over, rx_under, rx_over;

  int total = 0, bad = 0;
  bit done = 0;
  string tag_ovr = "";

  logic [10:0] tq[$];
  logic [7:0]  rq[$];
  logic [3:0]  m_txthr, m_rxthr;
  logic [2:0]  m_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_queue_top #(.DEPTH(D)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] canon(input logic [10:0] w);
    return w[8] ? {w[10:8], 8'h00} : w;
  endfunction

  function automatic logic [10:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return (rq.size() == 0) ? 11'd0 : {3'b0, rq[0]};
      3'd1: return 11'(tq.size());
      3'd2: return 11'(rq.size());
      3'd3: return 11'(m_txthr);
      3'd4: return 11'(m_rxthr);
      3'd5: return 11'(m_fl);
      default: return 11'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    if (tag_ovr != "") return tag_ovr;
    case (a)
      3'd0: return (rq.size() == 0) ? "R7" : "R1";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic cyc(input bit wr, input bit rd, input logic [2:0] a, input logic [10:0] wd,
                     input bit rdy, input bit rv, input logic [7:0] rb, input bit ab);
    bit to, su, so, txfull, rxfull, rxempty;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    cmd_ready = rdy; rxb_valid = rv; rxb_data = rb; xfer_abort = ab;
    #1;
    chk("R1", {31'd0, cmd_valid}, {31'd0, tq.size() > 0});
    if (tq.size() > 0) chk(tq[0][8] ? "R2" : "R1", 32'(cmd_data), 32'(tq[0]));
    chk("R4", {31'd0, tx_empty_lvl}, {31'd0, tq.size() <= int'(m_txthr)});
    chk("R5", {31'd0, rx_full_lvl}, {31'd0, rq.size() > int'(m_rxthr)});
    chk("R6", {31'd0, tx_over}, {31'd0, m_fl[0]});
    chk("R7", {31'd0, rx_under}, {31'd0, m_fl[1]});
    chk("R8", {31'd0, rx_over}, {31'd0, m_fl[2]});
    if (rd) chk(rd_tag(a), 32'(reg_rdata), 32'(exp_rd(a)));
    @(posedge clk);
    to = 0; su = 0; so = 0;
    if (ab) begin
      tq.delete(); rq.delete();
    end else begin
      txfull = (tq.size() == D); rxfull = (rq.size() == D); rxempty = (rq.size() == 0);
      if (rdy && tq.size() > 0) void'(tq.pop_front());
      if (wr && a == 3'd0) begin
        if (txfull) to = 1; else tq.push_back(canon(wd));
      end
      if (rd && a == 3'd0) begin
        if (rxempty) su = 1; else void'(rq.pop_front());
      end
      if (rv) begin
        if (rxfull) so = 1; else rq.push_back(rb);
      end
    end
    m_fl = (m_fl & ~((wr && a == 3'd5) ? wd[2:0] : 3'b000)) | {so, su, to};
    if (wr && a == 3'd3) m_txthr = wd[3:0];
    if (wr && a == 3'd4) m_rxthr = wd[3:0];
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rdreg(input logic [2:0] a); cyc(0, 1, a, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    m_txthr = 4'(D / 2); m_rxthr = 0; m_fl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    tag_ovr = "R12";
    rdreg(3'd1); rdreg(3'd2); rdreg(3'd3); rdreg(3'd4); rdreg(3'd5);
    tag_ovr = "";

    // R2/R6: fill tx with mixed writes and reads, then overflow
    for (int i = 0; i < D; i++) cyc(1, 0, 0, 11'((i % 3 == 0) ? (11'h1A5 | (i << 9)) : i + 8'h30), 0, 0, 0, 0);
    cyc(1, 0, 0, 11'h055, 1, 0, 0, 0);  // full at start, pop same cycle: dropped
    tag_ovr = "R6"; rdreg(3'd1); rdreg(3'd5); tag_ovr = "";
    cyc(1, 0, 3'd5, 11'h007, 0, 0, 0, 0); // R11 clear

    // R10: push and pop together when not full
    cyc(1, 0, 0, 11'h3C1, 1, 0, 0, 0);
    tag_ovr = "R10"; rdreg(3'd1); tag_ovr = "";
    repeat (D + 1) cyc(0, 0, 0, 0, 1, 0, 0, 0);

    // R7 underflow, R8 overflow with simultaneous pop
    rdreg(3'd0);
    for (int i = 0; i < D; i++) cyc(0, 0, 0, 0, 0, 1, 8'(8'hA0 + i), 0);
    cyc(0, 1, 0, 0, 0, 1, 8'hEE, 0);
    tag_ovr = "R8"; rdreg(3'd2); rdreg(3'd5); tag_ovr = "";
    tag_ovr = "R10"; cyc(0, 1, 0, 0, 0, 1, 8'h77, 0); rdreg(3'd2); tag_ovr = "";

    // R9: abort with traffic on both queues
    cyc(1, 0, 0, 11'h012, 0, 0, 0, 0);
    cyc(1, 0, 0, 11'h013, 1, 1, 8'h44, 1);
    tag_ovr = "R9"; rdreg(3'd1); rdreg(3'd2); rdreg(3'd5); tag_ovr = "";

    // R4/R5 watermark boundaries
    cyc(1, 0, 3'd3, 11'd0, 0, 0, 0, 0);
    cyc(1, 0, 3'd4, 11'd1, 0, 0, 0, 0);
    cyc(1, 0, 0, 11'h021, 0, 1, 8'h11, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h12, 0);
    idle();
    cyc(1, 0, 3'd3, 11'd8, 0, 0, 0, 0);
    cyc(1, 0, 3'd4, 11'd8, 0, 0, 0, 0);
    idle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] a;
      bit w, rdb;
      r = int'($urandom % 4);
      a = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd0;
      w = (r == 1); rdb = (r == 2);
      cyc(w, rdb, a, 11'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
          8'($urandom), ($urandom % 97) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule